// File: doc/BRIEF.md
# Warp Memory Access Coalescer

This block takes one warp's load or store, with a lane-enable mask, one address per lane and a single access width, and turns it into the smallest set of aligned memory transactions that covers every enabled lane. Each transaction carries a base address, a size of 32, 64 or 128 bytes, the set of lanes it serves, a byte-enable mask over a 128-byte window, and the write flag copied from the request. Atomic requests are handled in a separate way: two lanes never share a transaction if their bytes overlap, so every read-modify-write stays distinct.

Lanes are first grouped into an aligned segment. The segment size depends on the access width. A group is then narrowed to the smallest aligned 64-byte or 32-byte window that holds the 32-byte chunks its lanes start in. The request port and the transaction port are both valid/ready. A request is accepted only when no transaction of the previous request is still waiting, so `req_ready` is high exactly when the block is idle. A transaction holds all its fields steady while `txn_ready` is low, and it retires on the clock edge where both `txn_valid` and `txn_ready` are high. The block places no limit on how long `txn_ready` may stay low.

Top module: `warp_coalescer`

## Requirements
- R1: The width code `req_szl` gives 2^code bytes per lane (0=1 B, 1=2 B, 2=4 B, 3=8 B, 4=16 B). The segment is 32 B for code 0, 64 B for code 1 and 128 B for codes 2 to 4. Every lane's block address is its own address rounded down to the segment size. A transaction's base lies inside its block, and the transaction is never larger than the segment.
- R2: In non-atomic mode, each distinct block within a sub-warp yields exactly one transaction. The `txn_lanes` bit i of that transaction is set exactly for the enabled lanes i of that sub-warp that fall in the block.
- R3: `txn_bmask` bit j is set when some lane of the transaction touches byte j of the 128-byte-aligned window. A lane touches 2^code bytes, starting at its address mod 128.
- R4: For a 128 B segment, the 32-byte chunk of a lane is (address mod 128)/32. If only chunks 0–1 are used, the transaction is 64 B at the block base. If only chunks 2–3 are used, it is 64 B at the block base plus 64. Otherwise it stays 128 B.
- R5: When a transaction is 64 B and only one of its two 32-byte halves is used, it shrinks to 32 B. If that half is the upper one, the base is raised by 32.
- R6: For a native 64 B segment, the two halves come from chunks 0–1 when the block is 128-aligned, and from chunks 2–3 otherwise.
- R7: In atomic mode the warp is always split into two halves. Within a block, each lane, taken in lane order, joins the first open transaction whose byte mask does not overlap its own bytes. If there is none, the lane opens a new transaction.
- R8: Sub-warps are emitted in ascending order. Within a sub-warp, blocks are emitted in ascending address order. Within a block, atomic transactions are emitted in the order they were opened.
- R9: While `txn_valid` is high and `txn_ready` is low, every transaction field holds its value.
- R10: A request with an all-zero lane mask emits nothing, and `req_ready` is high again on the next cycle.
- R11: After reset, `txn_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted |
| req_mask | input | LANES | Lane enables |
| req_addr | input | LANES*AW | Per-lane byte address, lane i at bits [i*AW +: AW] |
| req_szl | input | 3 | Access width code (log2 bytes) |
| req_write | input | 1 | Store when 1 |
| req_atomic | input | 1 | Atomic mode |
| txn_valid | output | 1 | Transaction present |
| txn_ready | input | 1 | Consumer takes the transaction |
| txn_base | output | AW | Transaction base address |
| txn_bytes | output | 8 | Transaction size: 32, 64 or 128 |
| txn_lanes | output | LANES | Lanes served |
| txn_bmask | output | 128 | Byte enables within the 128-byte window |
| txn_write | output | 1 | Store flag of the request |

## Verification
The bench builds the block with LANES=8 and PARTS=1. With this setting a normal request is one sub-warp and an atomic request is split into two halves of four lanes, so the two split rules look different at the ports. Eight lanes are few enough that the bench can sweep every width code in both modes over several address patterns: random scatter, a small pool of shared addresses that forces atomic overlap, unit-stride runs, and 32-byte strides. Together these reach all three segment sizes, every shrink case and repeated openings within one block. The consumer ready signal is driven pseudo-randomly, so stalls land in many positions within a transaction sequence.

// File: rtl/coal_pkg.sv
package coal_pkg;
  // Width code clamped to the legal range 0..4.
  function automatic logic [2:0] clamp_szl(input logic [2:0] szl);
    return (szl > 3'd4) ? 3'd4 : szl;
  endfunction

  // log2 of the segment size chosen by the access width.
  function automatic logic [2:0] seg_shift(input logic [2:0] szl);
    logic [2:0] c;
    c = clamp_szl(szl);
    return (c >= 3'd2) ? 3'd7 : (3'd5 + c);
  endfunction
endpackage

// File: rtl/coal_lane_sel.sv
module coal_lane_sel #(
  parameter int LANES = 32,
  parameter int PARTS = 1,
  parameter int AW    = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LANES-1:0]      pending,
  input  logic [LANES*AW-1:0]   addr_flat,
  input  logic [2:0]            szl,
  input  logic                  atomic,
  output logic [LANES-1:0]      sel,
  output logic [AW-1:0]         blk,
  output logic [3:0]            chunks,
  output logic [127:0]          bmask
);
  import coal_pkg::*;
  localparam int SWN = LANES / PARTS;
  localparam int SWA = LANES / 2;

  logic [LANES-1:0] elig_n, elig_a, elig;
  logic [LANES-1:0] lo_half, hi_half;

  // Lanes of the lowest sub-warp that still has pending lanes.
  always_comb begin
    logic found_n, found_a;
    logic [LANES-1:0] pm;
    elig_n = '0; elig_a = '0; found_n = 1'b0; found_a = 1'b0;
    for (int p = 0; p < PARTS; p++) begin
      for (int l = 0; l < LANES; l++) pm[l] = ((l / SWN) == p);
      if (!found_n && |(pending & pm)) begin
        elig_n = pending & pm; found_n = 1'b1;
      end
    end
    for (int p = 0; p < 2; p++) begin
      for (int l = 0; l < LANES; l++) pm[l] = ((l / SWA) == p);
      if (!found_a && |(pending & pm)) begin
        elig_a = pending & pm; found_a = 1'b1;
      end
    end
    elig = atomic ? elig_a : elig_n;
  end

  // Lowest block, then lane-order greedy fill (first-fit for atomics).
  always_comb begin
    logic [AW-1:0]  amask, a, b;
    logic [127:0]   acc, lb;
    logic           have;
    logic [7:0]     nbytes;
    amask  = {AW{1'b1}} << seg_shift(szl);
    nbytes = 8'd1 << clamp_szl(szl);
    have   = 1'b0;
    blk    = '0;
    for (int l = 0; l < LANES; l++) begin
      b = addr_flat[l*AW +: AW] & amask;
      if (elig[l] && (!have || b < blk)) begin
        blk  = b;
        have = 1'b1;
      end
    end
    acc = '0; sel = '0; chunks = '0;
    for (int l = 0; l < LANES; l++) begin
      a  = addr_flat[l*AW +: AW];
      lb = ((128'd1 << nbytes) - 128'd1) << a[6:0];
      if (elig[l] && ((a & amask) == blk) && (!atomic || (lb & acc) == '0)) begin
        sel[l]         = 1'b1;
        acc            = acc | lb;
        chunks[a[6:5]] = 1'b1;
      end
    end
    bmask = acc;
  end

  always_comb
    for (int l = 0; l < LANES; l++) begin
      lo_half[l] = (l < SWA);
      hi_half[l] = (l >= SWA);
    end

  // R2
  sel_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|pending) |-> (sel != '0 && (sel & ~pending) == '0));

  // R7
  atomic_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (atomic && |sel) |-> !(|(sel & lo_half) && |(sel & hi_half)));
endmodule

// File: rtl/coal_shrink.sv
module coal_shrink #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid,
  input  logic [AW-1:0] blk,
  input  logic [2:0]    szl,
  input  logic [3:0]    chunks,
  output logic [AW-1:0] base,
  output logic [7:0]    tbytes
);
  import coal_pkg::*;
  logic [2:0] sh;
  logic       lo, hi;
  logic [1:0] h;

  always_comb begin
    sh     = seg_shift(szl);
    lo     = chunks[0] | chunks[1];
    hi     = chunks[2] | chunks[3];
    base   = blk;
    h      = 2'b00;
    tbytes = 8'd32;
    if (sh == 3'd7) begin
      tbytes = 8'd128;
      if (lo && !hi) begin
        tbytes = 8'd64; h = chunks[1:0];
      end else if (!lo && hi) begin
        tbytes = 8'd64; h = chunks[3:2]; base = blk + AW'(64);
      end
    end else if (sh == 3'd6) begin
      tbytes = 8'd64;
      h = blk[6] ? chunks[3:2] : chunks[1:0];
    end
    if (tbytes == 8'd64) begin
      if (h == 2'b01) begin
        tbytes = 8'd32;
      end else if (h == 2'b10) begin
        tbytes = 8'd32; base = base + AW'(32);
      end
    end
  end

  // R1
  size_in_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (({1'b0, tbytes} <= (9'd1 << sh)) && base >= blk));

  // R4
  base_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ((base & AW'(tbytes - 8'd1)) == '0));
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer #(
  parameter int LANES = 32,
  parameter int PARTS = 1,
  parameter int AW    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [LANES-1:0]    req_mask,
  input  logic [LANES*AW-1:0] req_addr,
  input  logic [2:0]          req_szl,
  input  logic                req_write,
  input  logic                req_atomic,
  output logic                txn_valid,
  input  logic                txn_ready,
  output logic [AW-1:0]       txn_base,
  output logic [7:0]          txn_bytes,
  output logic [LANES-1:0]    txn_lanes,
  output logic [127:0]        txn_bmask,
  output logic                txn_write
);
  logic [LANES-1:0]    pend_q;
  logic [LANES*AW-1:0] addr_q;
  logic [2:0]          szl_q;
  logic                wr_q, atom_q;
  logic [LANES-1:0]    sel;
  logic [AW-1:0]       blk;
  logic [3:0]          chunks;

  assign req_ready = (pend_q == '0);
  assign txn_valid = !req_ready;
  assign txn_lanes = sel;
  assign txn_write = wr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      addr_q <= '0;
      szl_q  <= '0;
      wr_q   <= 1'b0;
      atom_q <= 1'b0;
    end else if (req_valid && req_ready) begin
      pend_q <= req_mask;
      addr_q <= req_addr;
      szl_q  <= req_szl;
      wr_q   <= req_write;
      atom_q <= req_atomic;
    end else if (txn_valid && txn_ready) begin
      pend_q <= pend_q & ~sel;
    end
  end

  coal_lane_sel #(.LANES(LANES), .PARTS(PARTS), .AW(AW)) u_sel (
    .clk(clk), .rst_n(rst_n), .pending(pend_q), .addr_flat(addr_q),
    .szl(szl_q), .atomic(atom_q), .sel(sel), .blk(blk),
    .chunks(chunks), .bmask(txn_bmask)
  );

  coal_shrink #(.AW(AW)) u_shrink (
    .clk(clk), .rst_n(rst_n), .valid(txn_valid), .blk(blk), .szl(szl_q),
    .chunks(chunks), .base(txn_base), .tbytes(txn_bytes)
  );

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && !txn_ready) |=> (txn_valid && $stable(txn_base) &&
      $stable(txn_lanes) && $stable(txn_bytes) && $stable(txn_bmask)));

  // R10
  empty_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_mask == '0) |=> req_ready);

  // R3
  bmask_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> (txn_bmask != '0));
endmodule

// File: tb/test_warp_coalescer.sv
module test_warp_coalescer;
  localparam int L  = 8;
  localparam int AW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [L-1:0] req_mask = '0;
  logic [L*AW-1:0] req_addr = '0;
  logic [2:0] req_szl = '0;
  logic req_write = 1'b0, req_atomic = 1'b0;
  logic txn_valid, txn_ready = 1'b0, txn_write;
  logic [AW-1:0] txn_base;
  logic [7:0] txn_bytes;
  logic [L-1:0] txn_lanes;
  logic [127:0] txn_bmask;

  always #10 clk = ~clk;

  warp_coalescer #(.LANES(L), .PARTS(1), .AW(AW)) i_warp_coalescer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mask(req_mask), .req_addr(req_addr), .req_szl(req_szl),
    .req_write(req_write), .req_atomic(req_atomic), .txn_valid(txn_valid),
    .txn_ready(txn_ready), .txn_base(txn_base), .txn_bytes(txn_bytes),
    .txn_lanes(txn_lanes), .txn_bmask(txn_bmask), .txn_write(txn_write)
  );

  int checks = 0, errors = 0;
  logic [31:0] rs = 32'h1234_5678;
  logic [31:0] la [L];
  logic [31:0] ex_base [16];
  int          ex_size [16];
  logic [L-1:0] ex_lanes [16];
  logic [127:0] ex_bm [16];
  int nexp;

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x;
    x = s ^ (s << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
    return x;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Reference model, built from the requirement text.
  task automatic build_expected(input logic [L-1:0] m, input int szl, input bit atom);
    int nparts, sw, seg, nb;
    logic [31:0] b, lastb, cand;
    bit have_last, have;
    logic [L-1:0] tl [L];
    logic [127:0] tb [L];
    int ntx, cmin, cmax;
    nexp = 0;
    nparts = atom ? 2 : 1;
    sw = L / nparts;
    seg = (szl >= 2) ? 128 : (32 << szl);
    nb = 1 << szl;
    for (int p = 0; p < nparts; p++) begin
      have_last = 0; lastb = 0;
      while (1) begin
        have = 0; b = 0;
        for (int l = p*sw; l < (p+1)*sw; l++) begin
          cand = la[l] & ~(seg - 1);
          if (m[l] && (!have_last || cand > lastb) && (!have || cand < b)) begin
            b = cand; have = 1;
          end
        end
        if (!have) break;
        ntx = 0;
        for (int l = p*sw; l < (p+1)*sw; l++) begin
          logic [127:0] lb;
          bit placed;
          if (!m[l] || (la[l] & ~(seg - 1)) != b) continue;
          lb = ((128'd1 << nb) - 1) << (la[l] % 128);
          placed = 0;
          for (int k = 0; k < ntx; k++) begin
            if (!placed && (!atom || (tb[k] & lb) == 0)) begin
              tl[k][l] = 1'b1; tb[k] = tb[k] | lb; placed = 1;
            end
          end
          if (!placed) begin
            tl[ntx] = '0; tl[ntx][l] = 1'b1; tb[ntx] = lb; ntx++;
          end
        end
        for (int k = 0; k < ntx; k++) begin
          logic [31:0] w;
          cmin = 4; cmax = -1;
          for (int l = 0; l < L; l++)
            if (tl[k][l]) begin
              int c;
              c = int'((la[l] % 128) / 32);
              if (c < cmin) cmin = c;
              if (c > cmax) cmax = c;
            end
          w = b & ~32'd127;
          if (seg == 32) begin
            ex_base[nexp] = b; ex_size[nexp] = 32;
          end else if (cmin == cmax) begin
            ex_base[nexp] = w + 32*cmin; ex_size[nexp] = 32;
          end else if (cmin/2 == cmax/2) begin
            ex_base[nexp] = w + 64*(cmin/2); ex_size[nexp] = 64;
          end else begin
            ex_base[nexp] = b; ex_size[nexp] = 128;
          end
          ex_lanes[nexp] = tl[k]; ex_bm[nexp] = tb[k];
          nexp++;
        end
        lastb = b; have_last = 1;
      end
    end
  endtask

  task automatic run_req(input logic [L-1:0] m, input int szl, input bit atom, input bit wr);
    int got, seg;
    bit stalled;
    logic [31:0] hb;
    logic [L-1:0] hl;
    string stag, btag;
    seg = (szl >= 2) ? 128 : (32 << szl);
    stag = (seg == 128) ? "R4" : (seg == 64) ? "R6" : "R1";
    btag = atom ? "R7" : "R2";
    build_expected(m, szl, atom);
    @(negedge clk);
    for (int l = 0; l < L; l++) req_addr[l*AW +: AW] = la[l];
    req_mask = m; req_szl = 3'(szl); req_atomic = atom; req_write = wr;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (m == '0) begin
      chk(req_ready && !txn_valid, "R10", "empty request idle", {126'd0, req_ready, txn_valid}, 128'd2);
    end
    got = 0; stalled = 0; hb = '0; hl = '0;
    for (int cyc = 0; cyc < 200 && !req_ready; cyc++) begin
      if (stalled)
        chk(txn_valid && txn_base == hb && txn_lanes == hl, "R9", "hold under stall",
            {txn_base, 8'(txn_lanes)}, {hb, 8'(hl)});
      rs = nxt(rs);
      txn_ready = rs[3] | rs[5];
      if (txn_valid && txn_ready) begin
        if (got < nexp) begin
          chk(txn_lanes == ex_lanes[got], btag, "lanes", 128'(txn_lanes), 128'(ex_lanes[got]));
          chk(txn_bmask == ex_bm[got], "R3", "byte mask", txn_bmask, ex_bm[got]);
          chk(int'(txn_bytes) == ex_size[got], stag, "size", 128'(txn_bytes), 128'(ex_size[got]));
          chk(txn_base == ex_base[got], (ex_size[got] == 32 && seg != 32) ? "R5" : "R1", "base",
              128'(txn_base), 128'(ex_base[got]));
          chk(txn_write == wr, "R2", "write flag", 128'(txn_write), 128'(wr));
        end
        got++;
      end
      stalled = txn_valid && !txn_ready;
      hb = txn_base; hl = txn_lanes;
      @(negedge clk);
    end
    txn_ready = 1'b0;
    chk(got == nexp && req_ready, "R8", "transaction count", 128'(got), 128'(nexp));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11
    chk(req_ready && !txn_valid, "R11", "reset state", {126'd0, req_ready, txn_valid}, 128'd2);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !txn_valid, "R11", "idle after reset", {126'd0, req_ready, txn_valid}, 128'd2);
    for (int l = 0; l < L; l++) la[l] = 32'h4000;
    run_req('0, 2, 0, 0);
    run_req('0, 0, 1, 1);
    // Same word in every lane: atomics open one transaction per lane and half.
    for (int l = 0; l < L; l++) la[l] = 32'h4044;
    run_req('1, 2, 1, 1);
    run_req('1, 2, 0, 0);
    for (int szl = 0; szl <= 4; szl++)
      for (int atom = 0; atom < 2; atom++)
        for (int mode = 0; mode < 4; mode++)
          for (int rep = 0; rep < 8; rep++) begin
            int nb;
            logic [31:0] off;
            logic [L-1:0] m;
            nb = 1 << szl;
            rs = nxt(rs); off = rs & 32'h1FF;
            for (int l = 0; l < L; l++) begin
              rs = nxt(rs);
              case (mode)
                0: la[l] = 32'h4000 + (rs & 32'h1FF);
                1: la[l] = 32'h4000 + 32'h48 * (rs % 3);
                2: la[l] = 32'h4000 + off + l * nb;
                default: la[l] = 32'h4000 + l * 32 + (rs & 32'h1F);
              endcase
              la[l] = la[l] & ~(nb - 1);
            end
            rs = nxt(rs);
            m = (rep < 2) ? '1 : rs[L-1:0];
            run_req(m, szl, atom[0], rep[0]);
          end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule